// File: doc/BRIEF.md
# Quadrature Carrier Up-Converter

This block performs the last digital step before the converter: it multiplies baseband in-phase and quadrature samples by a locally generated cosine and sine carrier and combines them into one real output sample per clock. The carrier comes from a 32-bit phase accumulator that advances by a programmable tuning word every clock. Sine and cosine values are read from a 256-entry table inside the block, with the cosine taken a quarter turn ahead of the sine.

A 3-bit mode code picks the operation. Codes 000 to 011 cover the four quadrature schemes. These are phase, differential phase, 16-point amplitude/phase, and differential 16-point. All four use the same up-conversion, because symbol mapping and differential coding happen upstream. Code 100 selects frequency-shift keying. In that mode the block outputs the bare cosine carrier, and a data bit chooses, sample by sample, which of the two tuning words steps the accumulator. A sign input chooses whether the quadrature term is added or subtracted. A sleep input freezes the accumulator and silences the output.

Top module: `quad_upconverter`

## Requirements
- R1: After reset the output is 0 and the phase accumulator is 0. The first sample after reset is computed from phase 0.
- R2: With mode 000, 001, 010 or 011 and `spec_neg`=0, the output one cycle after the inputs are presented equals `i_in*C + q_in*S`. C and S are the cosine and sine of the accumulator phase before that clock edge. The result is full precision and signed.
- R3: With `spec_neg`=1 in the modes of R2, the output equals `i_in*C - q_in*S`.
- R4: In every mode other than 100, the accumulator advances by `tune_a` on each non-sleeping clock. In these modes `tune_b` and `fsk_bit` have no effect on the output.
- R5: In mode 100 the output is C, sign-extended, and `i_in`/`q_in` are ignored. The accumulator step is `tune_a` when `fsk_bit`=0 (space) and `tune_b` when `fsk_bit`=1 (mark).
- R6: The accumulator is never cleared when `fsk_bit` or the mode changes, so the phase stays continuous across such switches.
- R7: Mode codes 101, 110 and 111 behave exactly like 000.
- R8: While `sleep`=1 the output is 0 on the next cycle and the accumulator holds. After `sleep` returns to 0, stepping resumes from the held phase.
- R9: The table index is the top 8 accumulator bits k. S = round(2047·sin(2πk/256)). C is the table entry at (k+64) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_mode | input | 3 | Mode code; 100 = frequency-shift keying |
| tune_a | input | 32 | Carrier / space tuning word |
| tune_b | input | 32 | Mark tuning word (frequency-shift keying only) |
| spec_neg | input | 1 | 1 = subtract quadrature term |
| sleep | input | 1 | 1 = hold phase, force output to 0 |
| i_in | input | 12 | Signed in-phase sample |
| q_in | input | 12 | Signed quadrature sample |
| fsk_bit | input | 1 | Keying data bit |
| dout | output | 25 | Signed output sample |

## Verification
The hardest situation to reach is phase continuity. The test must show that the accumulator is never reset when the keying bit toggles, when the mode changes, or across a sleep interval. An error there shows up only as a wrong table index many samples later. The stimulus runs long stretches with irregular tuning words, so that many table entries are visited. It toggles `fsk_bit` on every sample, drops into and out of sleep mid-stream, and switches between frequency-shift keying and quadrature modes without reset. A bench-side phase model predicts every output sample across all of these transitions.

// File: rtl/quad_upconverter.sv
module quad_upconverter #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int SAMP_W  = 12,
  parameter int AMP_W   = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2:0]                        mod_mode,
  input  logic [PHASE_W-1:0]                tune_a,
  input  logic [PHASE_W-1:0]                tune_b,
  input  logic                              spec_neg,
  input  logic                              sleep,
  input  logic signed [SAMP_W-1:0]          i_in,
  input  logic signed [SAMP_W-1:0]          q_in,
  input  logic                              fsk_bit,
  output logic signed [SAMP_W+AMP_W:0]      dout
);
  localparam int OUT_W  = SAMP_W + AMP_W + 1;
  localparam int PROD_W = SAMP_W + AMP_W;
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int QTR    = LUT_N / 4;
  localparam int AMP    = (1 << (AMP_W - 1)) - 1;
  localparam logic [2:0] MODE_FSK = 3'b100;

  function automatic logic signed [AMP_W-1:0] sine_at(input int k);
    real r;
    r = AMP * $sin(2.0 * 3.141592653589793 * k / LUT_N);
    return AMP_W'($rtoi($floor(r + 0.5)));
  endfunction

  logic signed [AMP_W-1:0] sine_rom [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_rom
    assign sine_rom[g] = sine_at(g);
  end

  logic [PHASE_W-1:0] phase;
  logic [LUT_AW-1:0]  sin_idx, cos_idx;
  logic signed [AMP_W-1:0]  sin_v, cos_v;
  logic signed [PROD_W-1:0] prod_i, prod_q;
  logic signed [OUT_W-1:0]  ext_i, ext_q, mix, fsk_v;
  logic is_fsk;
  logic [PHASE_W-1:0] step;

  assign is_fsk  = (mod_mode == MODE_FSK);
  assign step    = (is_fsk && fsk_bit) ? tune_b : tune_a;
  assign sin_idx = phase[PHASE_W-1 -: LUT_AW];
  assign cos_idx = sin_idx + LUT_AW'(QTR);
  assign sin_v   = sine_rom[sin_idx];
  assign cos_v   = sine_rom[cos_idx];
  assign prod_i  = i_in * cos_v;
  assign prod_q  = q_in * sin_v;
  assign ext_i   = {prod_i[PROD_W-1], prod_i};
  assign ext_q   = {prod_q[PROD_W-1], prod_q};
  assign mix     = spec_neg ? ext_i - ext_q : ext_i + ext_q;
  assign fsk_v   = {{(OUT_W-AMP_W){cos_v[AMP_W-1]}}, cos_v};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      dout  <= '0;
    end else if (sleep) begin
      dout  <= '0;
    end else begin
      phase <= phase + step;
      dout  <= is_fsk ? fsk_v : mix;
    end
  end

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (dout == '0) && (phase == $past(phase)));

  // R4
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !is_fsk) |=> phase == $past(phase) + $past(tune_a));

  // R5
  fsk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && is_fsk) |=>
      phase == $past(phase) + ($past(fsk_bit) ? $past(tune_b) : $past(tune_a)));

  // R5
  fsk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && is_fsk) |=> (dout <= OUT_W'(AMP)) && (dout >= -OUT_W'(AMP)));
endmodule

// File: tb/test_quad_upconverter.sv
module test_quad_upconverter;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    longint val;
    string  tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] mod_mode = 3'b000;
  logic [31:0] tune_a = '0, tune_b = '0;
  logic spec_neg = 0, sleep = 0, fsk_bit = 0;
  logic signed [11:0] i_in = '0, q_in = '0;
  logic signed [24:0] dout;

  int checks = 0, failures = 0;
  exp_t sb[$];
  logic [31:0] mph = '0;
  bit done = 0;

  quad_upconverter i_quad_upconverter (
    .clk(clk), .rst_n(rst_n), .mod_mode(mod_mode), .tune_a(tune_a),
    .tune_b(tune_b), .spec_neg(spec_neg), .sleep(sleep), .i_in(i_in),
    .q_in(q_in), .fsk_bit(fsk_bit), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint tbl(input int k);
    real r;
    r = 2047.0 * $sin(2.0 * 3.141592653589793 * (k % 256) / 256.0);
    return longint'($rtoi($floor(r + 0.5)));
  endfunction

  task automatic drive(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                       input logic sn, input logic sl, input int iv, input int qv,
                       input logic fb, input string tag);
    exp_t e;
    int k;
    longint c, s;
    @(negedge clk);
    mod_mode = m; tune_a = a; tune_b = b; spec_neg = sn; sleep = sl;
    i_in = 12'(iv); q_in = 12'(qv); fsk_bit = fb;
    k = int'(mph[31:24]);
    s = tbl(k);
    c = tbl((k + 64) % 256);
    if (sl) e.val = 0;
    else if (m == 3'b100) e.val = c;
    else e.val = longint'(iv) * c + (sn ? -(longint'(qv) * s) : longint'(qv) * s);
    e.tag = tag;
    sb.push_back(e);
    if (!sl) mph = mph + ((m == 3'b100 && fb) ? b : a);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (longint'(dout) != e.val) begin
          failures++;
          $display("FAIL %s: dout=%0d expected=%0d", e.tag, longint'(dout), e.val);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] wa, wb;
    wa = 32'h0345_6789;
    wb = 32'h0B1C_2D3F;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== '0) begin
      failures++;
      $display("FAIL R1: reset dout=%0d expected=0", dout);
    end
    rst_n = 1;
    // R1: first sample uses phase 0
    drive(3'b000, wa, wb, 0, 0, 1000, -700, 0, "R1");
    // R2: quadrature sum, all four quadrature modes
    for (int n = 0; n < 160; n++)
      drive(3'(n % 4), wa, wb, 0, 0, int'($urandom_range(0, 4095)) - 2048,
            int'($urandom_range(0, 4095)) - 2048, 0, "R2");
    // R2 extremes
    for (int n = 0; n < 20; n++) drive(3'b010, wa, wb, 0, 0, -2048, -2048, 0, "R2");
    for (int n = 0; n < 20; n++) drive(3'b011, wa, wb, 0, 0, 2047, -2048, 0, "R2");
    // R3: difference
    for (int n = 0; n < 80; n++)
      drive(3'(n % 4), wa, wb, 1, 0, int'($urandom_range(0, 4095)) - 2048,
            int'($urandom_range(0, 4095)) - 2048, 0, "R3");
    // R4: tune_b and fsk_bit have no effect outside mode 100
    for (int n = 0; n < 60; n++)
      drive(3'(n % 4), wa, 32'($urandom), n % 3 == 0, 0, 1500, 900, n[0], "R4");
    // R7: codes 101-111 behave as 000
    for (int n = 0; n < 60; n++)
      drive(3'(5 + n % 3), wa, 32'($urandom), 0, 0, int'($urandom_range(0, 4095)) - 2048,
            int'($urandom_range(0, 4095)) - 2048, n[0], "R7");
    // R5: keying, constant space then constant mark
    for (int n = 0; n < 40; n++) drive(3'b100, wa, wb, 0, 0, 2047, 2047, 0, "R5");
    for (int n = 0; n < 40; n++) drive(3'b100, wa, wb, 1, 0, -2048, 5, 1, "R5");
    // R6: toggling bit every sample, phase continuous
    for (int n = 0; n < 80; n++) drive(3'b100, wa, wb, 0, 0, 0, 0, n[0], "R6");
    // R6: leave keying mode without reset
    for (int n = 0; n < 30; n++) drive(3'b001, wa, wb, 0, 0, 1234, -321, 1, "R6");
    // R8: sleep holds phase, output zero, then resumes
    for (int n = 0; n < 10; n++) drive(3'b000, wa, wb, 0, 1, 2000, 2000, 0, "R8");
    for (int n = 0; n < 30; n++) drive(3'b000, wa, wb, 0, 0, 2000, -2000, 0, "R8");
    for (int n = 0; n < 5; n++) drive(3'b100, wa, wb, 0, 1, 0, 0, 1, "R8");
    for (int n = 0; n < 30; n++) drive(3'b100, wa, wb, 0, 0, 0, 0, n[1], "R8");
    // R9: slow sweep visits every table entry
    for (int n = 0; n < 520; n++) drive(3'b000, 32'h0080_0000, wb, 0, 0, 2047, 0, 0, "R9");
    for (int n = 0; n < 520; n++) drive(3'b000, 32'h0080_0000, wb, 0, 0, 0, 2047, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule